// File: doc/BRIEF.md
# Dual-Rate Jittered PWM Carrier Generator

This block derives the carrier timing for a coil-current chopper from a fixed system clock. A phase counter runs from zero up to the current period length minus one and then wraps. The cycle after each wrap carries a one-clock strobe that marks the start of a new carrier period. A downstream duty comparator uses the phase value and the strobe; that comparator is outside this block.

Two configuration inputs shape each period. The rate select halves the nominal period count, which doubles the carrier frequency and lowers current ripple within a micro-step. The jitter enable adds a bounded signed offset to every period length. The offset comes from a 7-bit pseudo-random sequence, so the carrier energy spreads away from the fundamental and its harmonics. Both inputs are read only on the clock edge where the counter wraps, so a period never changes length once it has begun.

The asynchronous active-low reset is synchronised internally before it is released. The default nominal count gives roughly 22.8 kHz at 125 MHz.

Top module: `pwmj_carrier`

## Requirements
- R1: While reset is asserted, `phase` is 0 and `period_start` is 0, whether reset is asserted during operation or at start-up. Release of reset takes effect after a two-stage synchroniser. The first period after release has length NOM_PERIOD.
- R2: `phase` rises by exactly one on each clock, from 0 up to L-1, where L is the length of the current period. On the next clock it returns to 0.
- R3: `period_start` is 1 for exactly the one cycle in which `phase` has just returned to 0 from L-1. It is 0 in every other cycle.
- R4: With jitter disabled, a period begun with `rate_sel`=0 lasts NOM_PERIOD clocks. A period begun with `rate_sel`=1 lasts floor(NOM_PERIOD/2) clocks.
- R5: With jitter enabled, a period lasts B + (v mod (2*JIT_MAX+1)) - JIT_MAX clocks. B is the base length from R4 and v is the sequence value held just before the boundary.
- R6: The 7-bit sequence starts at LFSR_SEED and is never zero. It advances at every period boundary whether or not jitter is enabled, with next = {v[5:0], v[6] xor v[5]}.
- R7: `rate_sel` and `jit_en` are sampled only on the clock edge where `phase` equals L-1. Changes at any other time do not alter the length of the running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_sel | input | 1 | 0: nominal carrier rate, 1: double rate |
| jit_en | input | 1 | 1: add pseudo-random offset to each period |
| period_start | output | 1 | One-cycle strobe at the start of each carrier period |
| phase | output | $clog2(NOM_PERIOD+JIT_MAX+1) | Position within the current period |

## Verification
The bench drives four fixed configurations: nominal rate and double rate, each with and without jitter. Comparing measured period lengths across these separates the halving of the base count from the jitter offset. Leaving jitter off for several periods and then enabling it shows whether the sequence kept advancing while it was unused, because the first jittered length depends on that. The bench also changes the configuration in the middle of periods and asserts reset mid-run, which tests that sampling happens only at the boundary and that the reset is asynchronous.

// File: rtl/pwmj_pkg.sv
package pwmj_pkg;

  localparam int unsigned LFSR_W = 7;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // x^7 + x^6 + 1, shift toward the MSB
  function automatic lfsr_t lfsr_step(input lfsr_t v);
    return {v[LFSR_W-2:0], v[LFSR_W-1] ^ v[LFSR_W-2]};
  endfunction

endpackage

// File: rtl/pwmj_rst_sync.sv
module pwmj_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwmj_lfsr.sv
module pwmj_lfsr
  import pwmj_pkg::*;
#(
  parameter lfsr_t SEED = 7'h5A
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output lfsr_t state
);

  lfsr_t state_q;
  lfsr_t state_d;

  always_comb begin
    state_d = state_q;
    if (adv) begin
      state_d = lfsr_step(state_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R6: the sequence never locks up at zero
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R6: without a boundary the sequence holds
  p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));

endmodule

// File: rtl/pwmj_len_calc.sv
module pwmj_len_calc
  import pwmj_pkg::*;
#(
  parameter int unsigned NOM_PERIOD = 5482,
  parameter int unsigned JIT_MAX    = 32,
  parameter int unsigned LEN_W      = 13
) (
  input  logic             rate_fast,
  input  logic             jit_on,
  input  lfsr_t            rnd,
  output logic [LEN_W-1:0] len
);

  localparam int unsigned HALF = NOM_PERIOD / 2;
  localparam int unsigned SPAN = 2 * JIT_MAX + 1;

  logic [LEN_W-1:0]  base;
  logic [LFSR_W-1:0] rem;

  always_comb begin
    base = rate_fast ? LEN_W'(HALF) : LEN_W'(NOM_PERIOD);
    rem  = rnd % LFSR_W'(SPAN);
    if (jit_on) begin
      len = base + LEN_W'(rem) - LEN_W'(JIT_MAX);
    end else begin
      len = base;
    end
  end

endmodule

// File: rtl/pwmj_phase_cnt.sv
module pwmj_phase_cnt #(
  parameter int unsigned NOM_PERIOD = 5482,
  parameter int unsigned LEN_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_next,
  output logic [LEN_W-1:0] phase,
  output logic [LEN_W-1:0] len_cur,
  output logic             wrap,
  output logic             period_start
);

  logic [LEN_W-1:0] phase_q, phase_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             strobe_q, strobe_d;
  logic             at_end;

  always_comb begin
    at_end   = (phase_q == len_q - LEN_W'(1));
    phase_d  = phase_q + LEN_W'(1);
    len_d    = len_q;
    strobe_d = 1'b0;
    if (at_end) begin
      phase_d  = '0;
      len_d    = len_next;
      strobe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      len_q    <= LEN_W'(NOM_PERIOD);
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      len_q    <= len_d;
      strobe_q <= strobe_d;
    end
  end

  assign phase        = phase_q;
  assign len_cur      = len_q;
  assign wrap         = at_end;
  assign period_start = strobe_q;

  // R3: the strobe only accompanies phase zero
  p_strobe_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (phase_q == '0));

  // R2: nonzero phase is the previous one plus one
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != '0) |-> (phase_q == $past(phase_q) + LEN_W'(1)));

  // R2: phase stays inside the running period
  p_phase_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < len_q);

  // R7: the period length changes only at a period start
  p_len_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(len_q) |-> strobe_q);

endmodule

// File: rtl/pwmj_carrier.sv
module pwmj_carrier
  import pwmj_pkg::*;
#(
  parameter int unsigned NOM_PERIOD = 5482,
  parameter int unsigned JIT_MAX    = 32,
  parameter lfsr_t       LFSR_SEED  = 7'h5A,
  localparam int unsigned LEN_W     = $clog2(NOM_PERIOD + JIT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             jit_en,
  output logic             period_start,
  output logic [LEN_W-1:0] phase
);

  logic             rst_n_s;
  logic             wrap;
  lfsr_t            rnd;
  logic [LEN_W-1:0] len_next;
  logic [LEN_W-1:0] len_cur;

  pwmj_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  pwmj_lfsr #(
    .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n_s),
    .adv  (wrap),
    .state(rnd)
  );

  pwmj_len_calc #(
    .NOM_PERIOD(NOM_PERIOD),
    .JIT_MAX   (JIT_MAX),
    .LEN_W     (LEN_W)
  ) u_len_calc (
    .rate_fast(rate_sel),
    .jit_on   (jit_en),
    .rnd      (rnd),
    .len      (len_next)
  );

  pwmj_phase_cnt #(
    .NOM_PERIOD(NOM_PERIOD),
    .LEN_W     (LEN_W)
  ) u_phase_cnt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .len_next    (len_next),
    .phase       (phase),
    .len_cur     (len_cur),
    .wrap        (wrap),
    .period_start(period_start)
  );

  // R4: fixed nominal period
  p_fixed_full_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wrap && !jit_en && !rate_sel) |=> (len_cur == LEN_W'(NOM_PERIOD)));

  // R4: fixed doubled rate
  p_fixed_half_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wrap && !jit_en && rate_sel) |=> (len_cur == LEN_W'(NOM_PERIOD / 2)));

  // R5: jittered length stays within the bound
  p_jit_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wrap && jit_en && !rate_sel) |=>
      ((len_cur >= LEN_W'(NOM_PERIOD - JIT_MAX)) &&
       (len_cur <= LEN_W'(NOM_PERIOD + JIT_MAX))));

endmodule

// File: tb/pwmj_carrier_tb_top.sv
module pwmj_carrier_tb_top;

  localparam int NOM  = 40;
  localparam int JIT  = 5;
  localparam int SEED = 90;
  localparam int LW   = $clog2(NOM + JIT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rate_sel = 1'b0;
  logic          jit_en = 1'b0;
  logic          period_start;
  logic [LW-1:0] phase;

  always #4 clk = ~clk;

  pwmj_carrier #(
    .NOM_PERIOD(NOM),
    .JIT_MAX   (JIT),
    .LFSR_SEED (7'(SEED))
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .jit_en      (jit_en),
    .period_start(period_start),
    .phase       (phase)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mid_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lfsr_next(input int v);
    return ((v << 1) & 127) | (((v >> 6) ^ (v >> 5)) & 1);
  endfunction

  // behavioural reference model
  int  sc, m_ph, m_len, m_lfsr;
  bit  m_ps, m_jit, m_prevjit, m_first;
  int  ended_len;
  bit  ended_jit, ended_prevjit, ended_first;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc = 0; m_ph = 0; m_len = NOM; m_lfsr = SEED; m_ps = 0;
      m_jit = 0; m_prevjit = 0; m_first = 1;
    end else if (sc < 2) begin
      sc++;
    end else if (m_ph == m_len - 1) begin
      ended_len     = m_len;
      ended_jit     = m_jit;
      ended_prevjit = m_prevjit;
      ended_first   = m_first;
      m_len = rate_sel ? NOM / 2 : NOM;
      if (jit_en) m_len = m_len + (m_lfsr % (2 * JIT + 1)) - JIT;
      m_lfsr    = lfsr_next(m_lfsr);
      m_prevjit = m_jit;
      m_jit     = jit_en;
      m_first   = 0;
      m_ph = 0;
      m_ps = 1;
    end else begin
      m_ph++;
      m_ps = 0;
    end
  end

  int prev_phase = 0;

  always @(negedge clk) begin
    string ltag;
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
    chk(int'(phase) == m_ph, (sc < 2) ? "R1 phase in reset" : "R2 phase", int'(phase), m_ph);
    chk(period_start == m_ps, (sc < 2) ? "R1 strobe in reset" : "R3 strobe", period_start, m_ps);
    if (period_start && m_ps) begin
      if (ended_first) ltag = "R1 first period length";
      else if (mid_flag) ltag = "R7 length after mid-period change";
      else if (ended_jit && !ended_prevjit) ltag = "R6 first jittered length";
      else if (ended_jit) ltag = "R5 jittered length";
      else ltag = "R4 fixed length";
      chk(prev_phase + 1 == ended_len, ltag, prev_phase + 1, ended_len);
      mid_flag = 0;
    end
    prev_phase = int'(phase);
  end

  task automatic wait_periods(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (period_start) k++;
    end
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk); while (int'(phase) != p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == '0, "R1 phase held in reset", int'(phase), 0);
    chk(!period_start, "R1 strobe held in reset", period_start, 0);
    rst_n = 1'b1;

    wait_periods(5);
    rate_sel = 1'b1;
    wait_periods(6);
    rate_sel = 1'b0;
    wait_periods(3);
    jit_en = 1'b1;
    wait_periods(20);
    rate_sel = 1'b1;
    wait_periods(20);

    for (int i = 0; i < 24; i++) begin
      wait_phase(7);
      rate_sel = i[0];
      jit_en   = i[1];
      mid_flag = 1;
      wait_phase(9);
      rate_sel = ~i[0];
      jit_en   = ~i[2];
      wait_periods(1);
    end
    wait_periods(2);

    wait_phase(11);
    #2 rst_n = 1'b0;
    #1;
    chk(phase == '0, "R1 async reset phase", int'(phase), 0);
    chk(!period_start, "R1 async reset strobe", period_start, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_periods(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule